// File: doc/BRIEF.md
# Card Host Interrupt Router

This block collects the event flags raised by the command, data and FIFO engines of a memory-card host controller into a single 13-bit request register. Each engine pulses a per-event set line when its condition occurs and a per-event clear line when software acknowledges it. A software-written mask suppresses chosen events, and the unmasked remainder is reduced onto one processor interrupt line.

When the DMA-enable control bit is high, the two FIFO service flags (receive data ready, transmit space available) are hidden from the processor interrupt. They drive two dedicated DMA request lines instead, so a DMA engine can move FIFO data without software seeing each request. Dedicated strobes for clock start/stop and for FIFO reads/writes update the clock-off and FIFO service flags directly.

Top module: `card_irq_router`

## Requirements
- R1: While reset is high, at the next clock edge the request register and the mask register become zero, and the interrupt and both DMA lines are low.
- R2: A set pulse on event bit i makes request bit i read 1 after the next rising edge, and the bit then stays 1 until a clear reaches it. Bit positions: 0 data done, 1 programming done, 2 end of command, 3 stop command, 4 clock off, 5 receive FIFO service, 6 transmit FIFO service, 7 timer, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 card acknowledge.
- R3: A clear pulse on bit i makes request bit i read 0 after the next rising edge; when a set and a clear of the same bit arrive in one cycle, the bit becomes 1.
- R4: A mask write stores the low 13 bits of the 16-bit write data in the mask register; bits 15:13 of the write data are ignored.
- R5: The processor interrupt is high exactly when some request bit is 1 while its mask bit is 0 (bits 5 and 6 included only while DMA is disabled).
- R6: While DMA-enable is high, request bits 5 and 6 never raise the processor interrupt, whatever their mask bits.
- R7: While DMA-enable is high, the receive DMA line equals request bit 5 and the transmit DMA line equals request bit 6; while it is low both lines are 0.
- R8: A clock-start strobe clears request bit 4 and a clock-stop strobe sets it; both in one cycle leave bit 4 set.
- R9: A receive-FIFO read strobe clears request bit 5 and a transmit-FIFO write strobe clears request bit 6, with a set of the same bit in the same cycle still winning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 13 | Per-event set pulses |
| evt_clr | input | 13 | Per-event clear pulses |
| clk_start | input | 1 | Clock-start strobe, clears bit 4 |
| clk_stop | input | 1 | Clock-stop strobe, sets bit 4 |
| rx_fifo_rd | input | 1 | Receive FIFO read strobe, clears bit 5 |
| tx_fifo_wr | input | 1 | Transmit FIFO write strobe, clears bit 6 |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 16 | Mask write data, low 13 bits kept |
| dma_en | input | 1 | DMA-enable control bit |
| cpu_irq | output | 1 | Processor interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| req_q | output | 13 | Request register contents |
| mask_q | output | 13 | Mask register contents |

## Verification
Every pulse, strobe and mask write lands in a register at the next rising edge, so the request and mask values and the interrupt and DMA lines they feed are due one edge after the stimulus cycle. The DMA-enable input reaches the interrupt and DMA lines with no register, so its effect is due in the same cycle it changes. The bench drives each stimulus at a falling edge, lets one rising edge pass, and compares all outputs 1 ns after that edge with DMA-enable still held, before any input moves again.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

    localparam int EVT_W = 13;

    // Event bit positions in the request and mask registers
    localparam int B_DATA_DONE  = 0;
    localparam int B_PROG_DONE  = 1;
    localparam int B_CMD_END    = 2;
    localparam int B_STOP_CMD   = 3;
    localparam int B_CLK_OFF    = 4;
    localparam int B_RX_SVC     = 5;
    localparam int B_TX_SVC     = 6;
    localparam int B_TIMER      = 7;
    localparam int B_DATA_ERR   = 8;
    localparam int B_RESP_ERR   = 9;
    localparam int B_RD_STALL   = 10;
    localparam int B_CARD_INT   = 11;
    localparam int B_CARD_ACK   = 12;

    typedef logic [EVT_W-1:0] evt_vec_t;

    typedef struct packed {
        logic clk_start;
        logic clk_stop;
        logic rx_read;
        logic tx_write;
    } strobe_t;

    typedef struct packed {
        evt_vec_t set;
        evt_vec_t clr;
    } evt_upd_t;

    typedef struct packed {
        logic cpu;
        logic rx_dma;
        logic tx_dma;
    } route_out_t;

    function automatic evt_vec_t one_hot(input int pos);
        evt_vec_t v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    // Bits that are redirected to DMA lines when DMA is enabled
    function automatic evt_vec_t fifo_svc_bits();
        return one_hot(B_RX_SVC) | one_hot(B_TX_SVC);
    endfunction

    // Fold the dedicated strobes into the generic set/clear vectors
    function automatic evt_upd_t merge_updates(input evt_vec_t s,
                                               input evt_vec_t c,
                                               input strobe_t st);
        evt_upd_t u;
        u.set = s;
        u.clr = c;
        if (st.clk_stop)  u.set = u.set | one_hot(B_CLK_OFF);
        if (st.clk_start) u.clr = u.clr | one_hot(B_CLK_OFF);
        if (st.rx_read)   u.clr = u.clr | one_hot(B_RX_SVC);
        if (st.tx_write)  u.clr = u.clr | one_hot(B_TX_SVC);
        return u;
    endfunction

endpackage

// File: rtl/cirq_update_merge.sv
module cirq_update_merge
    import cirq_pkg::*;
(
    input  evt_vec_t evt_set,
    input  evt_vec_t evt_clr,
    input  strobe_t  strobes,
    output evt_upd_t upd
);

    always_comb begin
        upd = merge_updates(evt_set, evt_clr, strobes);
    end

endmodule

// File: rtl/cirq_req_bank.sv
module cirq_req_bank
    import cirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_upd_t upd,
    output evt_vec_t req
);

    // One flag cell per event; set has priority over clear
    for (genvar i = 0; i < EVT_W; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                req[i] <= 1'b0;
            end else if (upd.set[i]) begin
                req[i] <= 1'b1;
            end else if (upd.clr[i]) begin
                req[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cirq_mask_reg.sv
module cirq_mask_reg
    import cirq_pkg::*;
#(
    parameter int IN_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IN_W-1:0] wdata,
    output evt_vec_t        mask
);

    evt_vec_t wr_val;

    if (IN_W > EVT_W) begin : g_trunc
        logic unused_hi;
        assign unused_hi = ^wdata[IN_W-1:EVT_W];
        assign wr_val    = wdata[EVT_W-1:0];
    end else if (IN_W == EVT_W) begin : g_exact
        assign wr_val = wdata;
    end else begin : g_extend
        assign wr_val = {{(EVT_W-IN_W){1'b0}}, wdata};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (we) begin
            mask <= wr_val;
        end
    end

endmodule

// File: rtl/cirq_route.sv
module cirq_route
    import cirq_pkg::*;
(
    input  evt_vec_t   req,
    input  evt_vec_t   mask,
    input  logic       dma_en,
    output route_out_t lines
);

    evt_vec_t eff_mask;
    evt_vec_t live;

    always_comb begin
        eff_mask     = mask | (dma_en ? fifo_svc_bits() : '0);
        live         = req & ~eff_mask;
        lines.cpu    = |live;
        lines.rx_dma = dma_en & req[B_RX_SVC];
        lines.tx_dma = dma_en & req[B_TX_SVC];
    end

endmodule

// File: rtl/card_irq_router.sv
module card_irq_router
    import cirq_pkg::*;
#(
    parameter int MASK_IN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [EVT_W-1:0]     evt_set,
    input  logic [EVT_W-1:0]     evt_clr,
    input  logic                 clk_start,
    input  logic                 clk_stop,
    input  logic                 rx_fifo_rd,
    input  logic                 tx_fifo_wr,
    input  logic                 mask_we,
    input  logic [MASK_IN_W-1:0] mask_wdata,
    input  logic                 dma_en,
    output logic                 cpu_irq,
    output logic                 rx_dma_req,
    output logic                 tx_dma_req,
    output logic [EVT_W-1:0]     req_q,
    output logic [EVT_W-1:0]     mask_q
);

    strobe_t    strobes;
    evt_upd_t   upd;
    evt_vec_t   req_r;
    evt_vec_t   mask_r;
    route_out_t lines;

    always_comb begin
        strobes.clk_start = clk_start;
        strobes.clk_stop  = clk_stop;
        strobes.rx_read   = rx_fifo_rd;
        strobes.tx_write  = tx_fifo_wr;
    end

    cirq_update_merge u_merge (
        .evt_set (evt_set),
        .evt_clr (evt_clr),
        .strobes (strobes),
        .upd     (upd)
    );

    cirq_req_bank u_bank (
        .clk (clk),
        .rst (rst),
        .upd (upd),
        .req (req_r)
    );

    cirq_mask_reg #(.IN_W(MASK_IN_W)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .we    (mask_we),
        .wdata (mask_wdata),
        .mask  (mask_r)
    );

    cirq_route u_route (
        .req    (req_r),
        .mask   (mask_r),
        .dma_en (dma_en),
        .lines  (lines)
    );

    assign cpu_irq    = lines.cpu;
    assign rx_dma_req = lines.rx_dma;
    assign tx_dma_req = lines.tx_dma;
    assign req_q      = req_r;
    assign mask_q     = mask_r;

endmodule

// File: rtl/cirq_checker.sv
module cirq_checker
    import cirq_pkg::*;
#(
    parameter int MASK_IN_W = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [EVT_W-1:0]     evt_set,
    input logic [EVT_W-1:0]     evt_clr,
    input logic                 clk_start,
    input logic                 clk_stop,
    input logic                 rx_fifo_rd,
    input logic                 tx_fifo_wr,
    input logic                 mask_we,
    input logic [MASK_IN_W-1:0] mask_wdata,
    input logic                 dma_en,
    input logic                 cpu_irq,
    input logic                 rx_dma_req,
    input logic                 tx_dma_req,
    input logic [EVT_W-1:0]     req_q,
    input logic [EVT_W-1:0]     mask_q
);

    localparam logic [EVT_W-1:0] FIFO_PAIR = 13'h0060;

    logic [EVT_W-1:0] all_set;
    logic [EVT_W-1:0] all_clr;
    logic [EVT_W-1:0] visible;

    always_comb begin
        all_set = evt_set | {8'b0, clk_stop, 4'b0};
        all_clr = evt_clr | {6'b0, tx_fifo_wr, rx_fifo_rd, clk_start, 4'b0};
        visible = req_q & ~mask_q & (dma_en ? ~FIFO_PAIR : '1);
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (req_q == '0 && mask_q == '0 && !cpu_irq && !rx_dma_req && !tx_dma_req));

    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((req_q & $past(all_set)) == $past(all_set)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((req_q ^ $past(req_q)) & ~$past(all_set | all_clr)) == '0));

    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((req_q & $past(all_clr & ~all_set)) == '0));

    assert_mask_write_R4: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask_q == $past(mask_wdata[EVT_W-1:0])));

    assert_irq_up_R5: assert property (@(posedge clk) disable iff (rst)
        (visible != '0) |-> cpu_irq);

    assert_irq_down_R6: assert property (@(posedge clk) disable iff (rst)
        (visible == '0) |-> !cpu_irq);

    assert_dma_off_R7: assert property (@(posedge clk) disable iff (rst)
        !dma_en |-> (!rx_dma_req && !tx_dma_req));

    assert_dma_follow_R7: assert property (@(posedge clk) disable iff (rst)
        dma_en |-> (rx_dma_req == req_q[5] && tx_dma_req == req_q[6]));

endmodule

bind card_irq_router cirq_checker #(.MASK_IN_W(MASK_IN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_set    (evt_set),
    .evt_clr    (evt_clr),
    .clk_start  (clk_start),
    .clk_stop   (clk_stop),
    .rx_fifo_rd (rx_fifo_rd),
    .tx_fifo_wr (tx_fifo_wr),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .dma_en     (dma_en),
    .cpu_irq    (cpu_irq),
    .rx_dma_req (rx_dma_req),
    .tx_dma_req (tx_dma_req),
    .req_q      (req_q),
    .mask_q     (mask_q)
);

// File: tb/tb_card_irq_router.sv
`timescale 1ns/1ps
module tb_card_irq_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] evt_set = '0;
    logic [12:0] evt_clr = '0;
    logic        clk_start = 1'b0;
    logic        clk_stop = 1'b0;
    logic        rx_fifo_rd = 1'b0;
    logic        tx_fifo_wr = 1'b0;
    logic        mask_we = 1'b0;
    logic [15:0] mask_wdata = '0;
    logic        dma_en = 1'b0;
    logic        cpu_irq;
    logic        rx_dma_req;
    logic        tx_dma_req;
    logic [12:0] req_q;
    logic [12:0] mask_q;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    card_irq_router dut (
        .clk(clk), .rst(rst), .evt_set(evt_set), .evt_clr(evt_clr),
        .clk_start(clk_start), .clk_stop(clk_stop),
        .rx_fifo_rd(rx_fifo_rd), .tx_fifo_wr(tx_fifo_wr),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .dma_en(dma_en),
        .cpu_irq(cpu_irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .req_q(req_q), .mask_q(mask_q)
    );

    // Entry: {set13, clr13, strobes4 = {start, stop, rx_rd, tx_wr}, dma1,
    //         mask_we1, mask_data16, exp_req13, exp_irq, exp_rx, exp_tx}
    localparam int NV = 15;
    localparam logic [63:0] VEC [NV] = '{
        {13'h0001, 13'h0000, 4'b0000, 1'b0, 1'b0, 16'h0000, 13'h0001, 1'b1, 1'b0, 1'b0}, // R2 set bit0
        {13'h0000, 13'h0000, 4'b0000, 1'b0, 1'b1, 16'hFFFF, 13'h0001, 1'b0, 1'b0, 1'b0}, // R5 masked
        {13'h1000, 13'h0001, 4'b0000, 1'b0, 1'b1, 16'h0000, 13'h1000, 1'b1, 1'b0, 1'b0}, // R3 clear bit0
        {13'h0060, 13'h0000, 4'b0000, 1'b1, 1'b0, 16'h0000, 13'h1060, 1'b1, 1'b1, 1'b1}, // R7 dma lines
        {13'h0000, 13'h1000, 4'b0000, 1'b1, 1'b0, 16'h0000, 13'h0060, 1'b0, 1'b1, 1'b1}, // R6 fifo hidden
        {13'h0000, 13'h0000, 4'b0010, 1'b1, 1'b0, 16'h0000, 13'h0040, 1'b0, 1'b0, 1'b1}, // R9 rx read
        {13'h0000, 13'h0000, 4'b0000, 1'b0, 1'b0, 16'h0000, 13'h0040, 1'b1, 1'b0, 1'b0}, // R7 dma off
        {13'h0020, 13'h0000, 4'b0001, 1'b0, 1'b0, 16'h0000, 13'h0020, 1'b1, 1'b0, 1'b0}, // R9 tx write
        {13'h0020, 13'h0020, 4'b0010, 1'b0, 1'b0, 16'h0000, 13'h0020, 1'b1, 1'b0, 1'b0}, // R3 set wins
        {13'h0000, 13'h0000, 4'b0100, 1'b0, 1'b0, 16'h0000, 13'h0030, 1'b1, 1'b0, 1'b0}, // R8 clock stop
        {13'h0000, 13'h0000, 4'b1000, 1'b0, 1'b0, 16'h0000, 13'h0020, 1'b1, 1'b0, 1'b0}, // R8 clock start
        {13'h0000, 13'h0000, 4'b1100, 1'b0, 1'b0, 16'h0000, 13'h0030, 1'b1, 1'b0, 1'b0}, // R8 both
        {13'h0000, 13'h0000, 4'b0000, 1'b0, 1'b1, 16'hE030, 13'h0030, 1'b0, 1'b0, 1'b0}, // R4 low bits
        {13'h0100, 13'h0000, 4'b0000, 1'b0, 1'b0, 16'h0000, 13'h0130, 1'b1, 1'b0, 1'b0}, // R5 unmasked bit8
        {13'h0000, 13'h1FFF, 4'b0000, 1'b0, 1'b0, 16'h0000, 13'h0000, 1'b0, 1'b0, 1'b0}  // R3 clear all
    };

    function automatic string tag_of(input int idx);
        case (idx)
            0:       return "R2";
            1:       return "R5";
            2:       return "R3";
            3:       return "R7";
            4:       return "R6";
            5:       return "R9";
            6:       return "R7";
            7:       return "R9";
            8:       return "R3";
            9:       return "R8";
            10:      return "R8";
            11:      return "R8";
            12:      return "R4";
            13:      return "R5";
            default: return "R3";
        endcase
    endfunction

    task automatic compare(input string tag, input string what,
                           input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        evt_set    = '0;
        evt_clr    = '0;
        clk_start  = 1'b0;
        clk_stop   = 1'b0;
        rx_fifo_rd = 1'b0;
        tx_fifo_wr = 1'b0;
        mask_we    = 1'b0;
        mask_wdata = '0;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        compare("R1", "req_q", {3'b0, req_q}, 16'h0);
        compare("R1", "mask_q", {3'b0, mask_q}, 16'h0);
        compare("R1", "lines", {13'b0, cpu_irq, rx_dma_req, tx_dma_req}, 16'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [63:0] v;
            v = VEC[i];
            @(negedge clk);
            evt_set    = v[63:51];
            evt_clr    = v[50:38];
            clk_start  = v[37];
            clk_stop   = v[36];
            rx_fifo_rd = v[35];
            tx_fifo_wr = v[34];
            dma_en     = v[33];
            mask_we    = v[32];
            mask_wdata = v[31:16];
            @(posedge clk);
            #1;
            idle_inputs();
            compare(tag_of(i), "req_q", {3'b0, req_q}, {3'b0, v[15:3]});
            compare(tag_of(i), "cpu_irq", {15'b0, cpu_irq}, {15'b0, v[2]});
            compare(tag_of(i), "rx_dma_req", {15'b0, rx_dma_req}, {15'b0, v[1]});
            compare(tag_of(i), "tx_dma_req", {15'b0, tx_dma_req}, {15'b0, v[0]});
        end

        // R4: upper write bits dropped in the readable mask
        @(negedge clk);
        mask_we = 1'b1; mask_wdata = 16'hFFFF;
        @(posedge clk); #1; idle_inputs();
        compare("R4", "mask_q", {3'b0, mask_q}, 16'h1FFF);

        // R6: dma enabled with fifo bits unmasked still keeps irq low
        @(negedge clk);
        mask_we = 1'b1; mask_wdata = 16'h0000; evt_set = 13'h0020; dma_en = 1'b1;
        @(posedge clk); #1; idle_inputs();
        compare("R6", "cpu_irq", {15'b0, cpu_irq}, 16'h0);
        compare("R7", "rx_dma_req", {15'b0, rx_dma_req}, 16'h1);
        // R6/R7: dropping dma_en acts in the same cycle
        @(negedge clk);
        dma_en = 1'b0;
        #1;
        compare("R6", "cpu_irq comb", {15'b0, cpu_irq}, 16'h1);
        compare("R7", "rx_dma_req comb", {15'b0, rx_dma_req}, 16'h0);

        // R1: reset in mid-run clears everything
        @(negedge clk);
        evt_set = 13'h1FFF; mask_we = 1'b1; mask_wdata = 16'h00FF;
        @(posedge clk); #1; idle_inputs();
        compare("R2", "req_q all", {3'b0, req_q}, 16'h1FFF);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        compare("R1", "req_q", {3'b0, req_q}, 16'h0);
        compare("R1", "mask_q", {3'b0, mask_q}, 16'h0);
        compare("R1", "cpu_irq", {15'b0, cpu_irq}, 16'h0);
        @(negedge clk);
        rst = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule